// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It runs a small load/store subset: register-register add, sub, and, or and set-on-less-than; OR with an immediate; word load and store; branch on equal; and an absolute jump. Each cycle the core shows its program counter, takes the fetched instruction word back, and drives a data-memory port. The data memory reads combinationally and writes on the clock edge while the write strobe is high.

Control has two levels. A main decoder reads the opcode and produces the datapath strobes plus a 2-bit ALU operation class. A small local decoder combines that class with the funct field to give a 3-bit ALU code. The datapath holds a 32-entry by 32-bit register file, the immediate extender, the operand and writeback selectors, the ALU and the next-PC logic.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC loads 0 on that edge, and `dmemWe` stays low while `rst` is high.
- R2: Every instruction other than a taken branch or a jump advances the PC by 4 on the next edge.
- R3: Opcode 000000 is register-register; bits [5:0] select the operation (100000 add, 100010 sub, 100100 and, 100101 or). The internal ALU codes are and=000, or=001, add=010, sub=110, slt=111.
- R4: Funct 101010 (slt) writes 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 001101 ORs rs with the zero-extended 16-bit immediate in bits [15:0] and writes the result to rt.
- R6: Opcode 100011 (load) and opcode 101011 (store) use the address rs plus the sign-extended immediate. The load writes the read data to rt. The store drives rt on `dmemWdata` with `dmemWe` high. `dmemWe` is high only for the store opcode.
- R7: Opcode 000100 compares rs and rt by subtraction. When they are equal the next PC is PC+4 plus the sign-extended immediate times 4; otherwise it is PC+4. No register is written.
- R8: Opcode 000010 sets the next PC to {PC+4 bits [31:28], bits [25:0] of the instruction, 00}.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: Any other opcode writes no register and no memory, and the PC advances by 4.
- R11: Register-register results go to rd (bits [15:11]). Immediate and load results go to rt (bits [20:16]). Source fields are rs in [25:21] and rt in [20:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pcOut | output | 32 | Byte address of the instruction to fetch |
| instrIn | input | 32 | Instruction word at `pcOut` |
| dmemAddr | output | 32 | Data-memory byte address |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe; memory writes on the rising edge |
| dmemRdata | input | 32 | Combinational read data at `dmemAddr` |

## Verification
Register contents are not visible at the ports, so the hardest results to show are the ones that leave nothing behind: a write aimed at register 0, an undefined opcode, and a branch or jump that skips instructions. The directed program plants "poison" instructions in every skipped slot. Each poison instruction would overwrite a marker register. At the end the program stores every register to a known memory window. The bench then reads that window and checks the register values, and it also checks a record of which instruction addresses were fetched.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluCode_t;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_OR    = 2'b10,
    AOP_FUNCT = 2'b11
  } aluOp_t;

  typedef struct packed {
    logic     regDst;
    logic     aluSrc;
    logic     memToReg;
    logic     regWrite;
    logic     memWrite;
    logic     branch;
    logic     jump;
    logic     zeroExt;
    aluCode_t aluCtl;
  } ctl_t;
endpackage

// File: rtl/scpu_alu_decode.sv
module scpu_alu_decode
  import scpu_pkg::*;
(
  input  aluOp_t     aluOp,
  input  logic [5:0] funct,
  output aluCode_t   aluCtl
);
  always_comb begin
    unique case (aluOp)
      AOP_ADD: aluCtl = ALU_ADD;
      AOP_SUB: aluCtl = ALU_SUB;
      AOP_OR:  aluCtl = ALU_OR;
      default: begin
        case (funct)
          FN_SUB:  aluCtl = ALU_SUB;
          FN_AND:  aluCtl = ALU_AND;
          FN_OR:   aluCtl = ALU_OR;
          FN_SLT:  aluCtl = ALU_SLT;
          default: aluCtl = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  aluOp_t   aluOp;
  aluCode_t aluCtlLocal;

  scpu_alu_decode u_aluDec (
    .aluOp  (aluOp),
    .funct  (funct),
    .aluCtl (aluCtlLocal)
  );

  always_comb begin
    ctl        = '0;
    aluOp      = AOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        aluOp        = AOP_FUNCT;
      end
      OP_ORI: begin
        ctl.aluSrc   = 1'b1;
        ctl.zeroExt  = 1'b1;
        ctl.regWrite = 1'b1;
        aluOp        = AOP_OR;
      end
      OP_LW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
      end
      OP_SW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        aluOp      = AOP_SUB;
      end
      OP_J: begin
        ctl.jump = 1'b1;
      end
      default: ;
    endcase
    ctl.aluCtl = aluCtlLocal;
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int AW = 5,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_t            ctl,
  input  logic [25:0]     instrLow,
  output logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata
);
  localparam int IMM_W = 16;

  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wbIdx;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0]   rsData, rtData, immExt, aluB, aluRes, wbData;
  logic [XLEN-1:0]   pcPlus4, brTarget, jTarget, pcNext;
  logic              isZero;

  assign rsIdx = instrLow[25:21];
  assign rtIdx = instrLow[20:16];
  assign rdIdx = instrLow[15:11];
  assign imm   = instrLow[IMM_W-1:0];

  scpu_regfile #(.AW(REG_AW), .W(XLEN)) u_regs (
    .clk (clk),
    .we  (ctl.regWrite & ~rst),
    .wa  (wbIdx),
    .wd  (wbData),
    .ra1 (rsIdx),
    .ra2 (rtIdx),
    .rd1 (rsData),
    .rd2 (rtData)
  );

  assign immExt = ctl.zeroExt ? {{(XLEN-IMM_W){1'b0}}, imm}
                              : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign aluB   = ctl.aluSrc ? immExt : rtData;

  always_comb begin
    case (ctl.aluCtl)
      ALU_SUB: aluRes = rsData - aluB;
      ALU_AND: aluRes = rsData & aluB;
      ALU_OR:  aluRes = rsData | aluB;
      ALU_SLT: aluRes = {{(XLEN-1){1'b0}}, $signed(rsData) < $signed(aluB)};
      default: aluRes = rsData + aluB;
    endcase
  end

  assign isZero = (aluRes == '0);
  assign wbIdx  = ctl.regDst ? rdIdx : rtIdx;
  assign wbData = ctl.memToReg ? memRdata : aluRes;

  assign memAddr  = aluRes;
  assign memWdata = rtData;

  assign pcPlus4  = pc + XLEN'(4);
  assign brTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jTarget  = {pcPlus4[XLEN-1:28], instrLow, 2'b00};

  always_comb begin
    if (ctl.jump)                 pcNext = jTarget;
    else if (ctl.branch && isZero) pcNext = brTarget;
    else                          pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_ADDR;
    else     pc <= pcNext;
  end
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  input  logic [31:0] instrIn,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWdata,
  output logic        dmemWe,
  input  logic [31:0] dmemRdata
);
  ctl_t ctl;

  scpu_control u_ctl (
    .opcode (instrIn[31:26]),
    .funct  (instrIn[5:0]),
    .ctl    (ctl)
  );

  scpu_datapath #(.RESET_ADDR(RESET_ADDR)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .instrLow (instrIn[25:0]),
    .pc       (pcOut),
    .memRdata (dmemRdata),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata)
  );

  assign dmemWe = ctl.memWrite & ~rst;
endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk
  import scpu_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instrIn,
  input logic        dmemWe
);
  logic [5:0]  op;
  logic [31:0] seqPc, jumpDest, branchDest;
  logic        knownOp;

  assign op         = instrIn[31:26];
  assign seqPc      = pcOut + 32'd4;
  assign jumpDest   = {seqPc[31:28], instrIn[25:0], 2'b00};
  assign branchDest = seqPc + {{14{instrIn[15]}}, instrIn[15:0], 2'b00};
  assign knownOp    = (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LW) ||
                      (op == OP_SW) || (op == OP_BEQ) || (op == OP_J);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pcOut == 32'd0); // R1
  AST_RESET_NO_STORE: assert property (@(posedge clk) rst |-> !dmemWe); // R1
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BEQ && op != OP_J) |=> pcOut == $past(seqPc)); // R2
  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> op == OP_SW); // R6
  AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (rst)
    op == OP_BEQ |=> (pcOut == $past(seqPc) || pcOut == $past(branchDest))); // R7
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    op == OP_J |=> pcOut == $past(jumpDest)); // R8
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> !dmemWe); // R10
endmodule

bind scpu_core scpu_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pcOut   (pcOut),
  .instrIn (instrIn),
  .dmemWe  (dmemWe)
);

// File: tb/scpu_core_test.sv
module scpu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut, instrIn, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemWe;

  logic [31:0] imem [64];
  logic [31:0] dmem [128];
  bit          visited [64];
  bit          tracking = 1'b0;
  int          nChecks = 0;
  int          nFails  = 0;

  localparam logic [5:0] OPR = 6'b000000, OPORI = 6'b001101, OPLW = 6'b100011,
                         OPSW = 6'b101011, OPBEQ = 6'b000100, OPJ = 6'b000010;
  localparam int HALT_WORD = 34;
  localparam int DUMP_WORD = 64;

  always #5 clk = ~clk;

  scpu_core uut (
    .clk       (clk),
    .rst       (rst),
    .pcOut     (pcOut),
    .instrIn   (instrIn),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemWe    (dmemWe),
    .dmemRdata (dmemRdata)
  );

  assign instrIn   = imem[pcOut[7:2]];
  assign dmemRdata = dmem[dmemAddr[8:2]];

  always @(posedge clk) if (dmemWe) dmem[dmemAddr[8:2]] <= dmemWdata;
  always @(negedge clk) if (tracking && !rst) visited[pcOut[7:2]] = 1'b1;

  function automatic logic [31:0] rInst(int rs, int rt, int rd, logic [5:0] fn);
    return {OPR, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iInst(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] jInst(int word);
    return {OPJ, 26'(word)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadProgram();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; visited[i] = 1'b0; end
    for (int i = 0; i < 128; i++) dmem[i] = 32'h0;
    dmem[1] = 32'hFFFF_FFF6;
    imem[0]  = iInst(OPORI, 0, 12, 16'h0055);
    imem[1]  = iInst(OPORI, 0, 1, 16'h00F0);
    imem[2]  = iInst(OPORI, 0, 2, 16'h8031);
    imem[3]  = iInst(OPLW, 0, 3, 16'h0004);
    imem[4]  = rInst(1, 2, 4, 6'b100000);
    imem[5]  = rInst(1, 2, 5, 6'b100010);
    imem[6]  = rInst(1, 2, 6, 6'b100100);
    imem[7]  = rInst(1, 2, 7, 6'b100101);
    imem[8]  = rInst(3, 1, 8, 6'b101010);
    imem[9]  = rInst(1, 3, 9, 6'b101010);
    imem[10] = rInst(1, 1, 0, 6'b100000);
    imem[11] = iInst(OPLW, 1, 10, 16'hFF14);
    imem[12] = {6'h3F, 5'd0, 5'd1, 16'hFFFF};
    imem[13] = iInst(OPBEQ, 1, 2, 16'd5);
    imem[14] = iInst(OPBEQ, 7, 7, 16'd2);
    imem[15] = iInst(OPORI, 0, 12, 16'hDEAD);
    imem[16] = iInst(OPORI, 0, 12, 16'hDEAD);
    imem[17] = jInst(21);
    for (int i = 18; i <= 20; i++) imem[i] = iInst(OPORI, 0, 12, 16'hDEAD);
    for (int k = 0; k <= 10; k++) imem[21 + k] = iInst(OPSW, 0, k, 16'(32'h100 + 4 * k));
    imem[32] = iInst(OPSW, 0, 12, 16'h0130);
    imem[33] = iInst(OPSW, 1, 3, 16'hFFF0);
    imem[HALT_WORD] = jInst(HALT_WORD);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", pcOut, 32'h0);
    check("R1 no store in reset", {31'd0, dmemWe}, 32'h0);
  endtask

  task automatic runProgram();
    bit done = 1'b0;
    tracking = 1'b1;
    rst = 1'b0;
    for (int c = 0; c < 400 && !done; c++) begin
      @(negedge clk);
      if (pcOut == 32'(HALT_WORD * 4)) done = 1'b1;
    end
    repeat (2) @(negedge clk);
    check("R2 program reached halt", pcOut, 32'(HALT_WORD * 4));
  endtask

  task automatic testArith();
    check("R3 R11 add to rd", dmem[DUMP_WORD + 4], 32'h0000_8121);
    check("R3 sub", dmem[DUMP_WORD + 5], 32'hFFFF_80BF);
    check("R3 and", dmem[DUMP_WORD + 6], 32'h0000_0030);
    check("R3 or", dmem[DUMP_WORD + 7], 32'h0000_80F1);
  endtask

  task automatic testSlt();
    check("R4 slt negative<positive", dmem[DUMP_WORD + 8], 32'h1);
    check("R4 slt positive<negative", dmem[DUMP_WORD + 9], 32'h0);
  endtask

  task automatic testOri();
    check("R5 R11 ori zero-extend to rt", dmem[DUMP_WORD + 2], 32'h0000_8031);
    check("R5 ori small", dmem[DUMP_WORD + 12], 32'h0000_0055);
  endtask

  task automatic testMemory();
    check("R6 lw positive offset", dmem[DUMP_WORD + 3], 32'hFFFF_FFF6);
    check("R6 lw negative offset", dmem[DUMP_WORD + 10], 32'hFFFF_FFF6);
    check("R6 sw negative offset", dmem[56], 32'hFFFF_FFF6);
    check("R6 no stray store", dmem[0], 32'h0);
  endtask

  task automatic testFlow();
    bit seqOk = 1'b1;
    for (int i = 0; i <= 14; i++) if (!visited[i]) seqOk = 1'b0;
    check("R2 sequential fetches", {31'd0, seqOk}, 32'h1);
    check("R7 taken beq skips word 15", {31'd0, visited[15]}, 32'h0);
    check("R7 taken beq skips word 16", {31'd0, visited[16]}, 32'h0);
    check("R7 taken beq lands", {31'd0, visited[17]}, 32'h1);
    check("R8 jump skips word 19", {31'd0, visited[19]}, 32'h0);
    check("R8 jump lands", {31'd0, visited[21]}, 32'h1);
  endtask

  task automatic testZeroReg();
    check("R9 r0 stays zero", dmem[DUMP_WORD + 0], 32'h0);
  endtask

  task automatic testUnknownOp();
    check("R10 unknown opcode leaves r1", dmem[DUMP_WORD + 1], 32'h0000_00F0);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    loadProgram();
    testReset();
    runProgram();
    testArith();
    testSlt();
    testOri();
    testMemory();
    testFlow();
    testZeroReg();
    testUnknownOp();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule